// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits between a UART receiver core and the host register interface. Each received character goes into a 64-entry queue. The character is stored together with three error tags: parity error, framing error and break. The queue drives two outputs. `rhr_data` presents the character at the head of the queue. `lsr` presents an 8-bit line status word that combines receive state, the head entry's tags, the overrun flag and two transmitter-empty inputs supplied from outside.

The host has two separate strobes. A status read (`lsr_rd`) leaves the queue untouched and clears the overrun flag. A data read (`rhr_rd`) removes the head entry. A counter tracks how many stored entries carry any error tag, and status bit 7 is set whenever that counter is non-zero.

Overrun is handled by a two-state machine with the states `OVR_IDLE` and `OVR_FLAGGED`:

- The transition `DROP` moves it from `OVR_IDLE` to `OVR_FLAGGED`. It fires when a character arrives while the queue is full and no data read frees a slot in the same cycle.
- The transition `ACK` moves it from `OVR_FLAGGED` back to `OVR_IDLE`. It fires on a status read in a cycle with no new drop.
- A `DROP` that occurs while in `OVR_FLAGGED` keeps the machine in `OVR_FLAGGED`.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset, the queue is empty, `lsr[4:0]` and `lsr[7]` are 0, and `rhr_data` is 0x00.
- R2: A write strobe accepted by the queue stores the byte and its three tags. `lsr[0]` is 1 whenever at least one character is stored and 0 when the queue is empty.
- R3: `rhr_data` shows the head byte. `lsr[4]`, `lsr[3]` and `lsr[2]` show the head entry's break, framing and parity tags. When the queue is empty, all of these read 0.
- R4: An entry written with the break tag set is stored with data 0x00, whatever byte was presented.
- R5: A status read alone never removes an entry: the head byte, the head tags and the fill level are unchanged after it.
- R6: A data read removes the head entry, and the next entry becomes the head one cycle later. A data read on an empty queue changes nothing.
- R7: `lsr[7]` is 1 while any stored entry carries a tag and drops to 0 once the last tagged entry is removed. The flag stays correct when a write and a data read happen in the same cycle.
- R8: A write into a full queue with no data read in the same cycle is discarded, and `lsr[1]` is set in the following cycle. `lsr[1]` stays set until a status read. It clears in the cycle after that read, unless another write is discarded in the same cycle as the read.
- R9: `lsr[5]` equals `tx_hold_empty`, and `lsr[6]` equals `tx_hold_empty AND tx_shift_empty`. Both are combinational.
- R10: The queue accepts exactly 64 characters before reporting full, and it returns them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the receiver core |
| wr_data | input | 8 | Received byte |
| wr_par | input | 1 | Parity error tag for the byte |
| wr_frm | input | 1 | Framing error tag (no valid stop bit) |
| wr_brk | input | 1 | Break tag (line low for a whole character time) |
| tx_hold_empty | input | 1 | Transmit holding register or TX queue is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| lsr_rd | input | 1 | Host status read strobe |
| rhr_rd | input | 1 | Host data read strobe; removes the head entry |
| rhr_data | output | 8 | Head byte, or 0x00 when empty |
| lsr | output | 8 | Line status word |

## Verification
The three kinds of internal fault show up at different times:

- A wrong read pointer appears at `rhr_data` and `lsr[4:2]` in the very next cycle after the faulty pop.
- A wrong fill count stays hidden until the queue reaches an edge. It then shows up as a missing or extra `lsr[0]`, or as a premature or missing overrun in `lsr[1]`, which may take up to 64 writes or reads to expose.
- A miscounted tagged-entry counter surfaces only when `lsr[7]` should change, that is, when the last tagged entry leaves. A full fill-and-drain pass with one tagged entry in the middle is therefore needed to expose it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic {
        OVR_IDLE    = 1'b0,
        OVR_FLAGGED = 1'b1
    } ovr_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       pop,
    input  rxq_entry_t din,
    output rxq_entry_t head,
    output logic [CW-1:0] count,
    output logic       full,
    output logic       empty
);
    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
endmodule

// File: rtl/rxq_err_tally.sv
module rxq_err_tally #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] err_cnt,
    output logic          any_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   err_cnt <= err_cnt + 1'b1;
                2'b01:   err_cnt <= err_cnt - 1'b1;
                default: err_cnt <= err_cnt;
            endcase
        end
    end

    assign any_err = (err_cnt != '0);
endmodule

// File: rtl/rxq_ovr_fsm.sv
module rxq_ovr_fsm
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic status_rd,
    output logic ovr_flag
);
    ovr_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OVR_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            OVR_IDLE:    if (drop) state_nx = OVR_FLAGGED;                 // DROP
            OVR_FLAGGED: if (status_rd && !drop) state_nx = OVR_IDLE;      // ACK
            default:     state_nx = OVR_IDLE;
        endcase
    end

    always_comb begin
        ovr_flag = 1'b0;
        unique case (state)
            OVR_IDLE:    ovr_flag = 1'b0;
            OVR_FLAGGED: ovr_flag = 1'b1;
            default:     ovr_flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_par,
    input  logic       wr_frm,
    input  logic       wr_brk,
    input  logic       tx_hold_empty,
    input  logic       tx_shift_empty,
    input  logic       lsr_rd,
    input  logic       rhr_rd,
    output logic [7:0] rhr_data,
    output logic [7:0] lsr
);
    rxq_entry_t    din, head;
    logic [CW-1:0] fill_cnt, err_cnt;
    logic          full, empty, push, pop, drop, any_err, ovr_flag;
    logic          head_tagged, din_tagged;

    assign pop  = rhr_rd && !empty;
    assign push = wr_en && (!full || pop);
    assign drop = wr_en && full && !pop;

    // Break characters are stored as 0x00 (R4)
    assign din.brk  = wr_brk;
    assign din.frm  = wr_frm;
    assign din.par  = wr_par;
    assign din.data = wr_brk ? '0 : wr_data;

    assign din_tagged  = wr_brk || wr_frm || wr_par;
    assign head_tagged = head.brk || head.frm || head.par;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (din),
        .head  (head),
        .count (fill_cnt),
        .full  (full),
        .empty (empty)
    );

    rxq_err_tally #(.DEPTH(DEPTH)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (push && din_tagged),
        .dec     (pop && head_tagged),
        .err_cnt (err_cnt),
        .any_err (any_err)
    );

    rxq_ovr_fsm u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop      (drop),
        .status_rd (lsr_rd),
        .ovr_flag  (ovr_flag)
    );

    always_comb begin
        rhr_data = empty ? 8'h00 : head.data;
        lsr[0]   = !empty;
        lsr[1]   = ovr_flag;
        lsr[2]   = !empty && head.par;
        lsr[3]   = !empty && head.frm;
        lsr[4]   = !empty && head.brk;
        lsr[5]   = tx_hold_empty;
        lsr[6]   = tx_hold_empty && tx_shift_empty;
        lsr[7]   = any_err;
    end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          lsr_rd,
    input logic          rhr_rd,
    input logic [7:0]    rhr_data,
    input logic [7:0]    lsr,
    input logic [CW-1:0] fill_cnt,
    input logic [CW-1:0] err_cnt
);
    logic is_full, is_drop;
    assign is_full = (fill_cnt == CW'(DEPTH));
    assign is_drop = wr_en && is_full && !rhr_rd;

    p_empty_head_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lsr[0] |-> (lsr[4:2] == 3'b000 && rhr_data == 8'h00));

    p_status_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rhr_rd && !wr_en) |=> ($stable(fill_cnt) && $stable(rhr_data)));

    p_empty_read_inert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsr[0] && rhr_rd && !wr_en) |=> ($stable(fill_cnt) && $stable(err_cnt)));

    p_tagged_within_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= fill_cnt);

    p_drop_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_drop |=> lsr[1]);

    p_ack_clears_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr[1] && lsr_rd && !is_drop) |=> !lsr[1]);

    p_tx_bits_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt <= CW'(DEPTH));
endmodule

bind uart_rx_fifo_status rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .lsr_rd   (lsr_rd),
    .rhr_rd   (rhr_rd),
    .rhr_data (rhr_data),
    .lsr      (lsr),
    .fill_cnt (fill_cnt),
    .err_cnt  (err_cnt)
);

// File: tb/uart_rx_fifo_status_tb_top.sv
module uart_rx_fifo_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_par = 1'b0, wr_frm = 1'b0, wr_brk = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_hold_empty = 1'b1, tx_shift_empty = 1'b0;
    logic       lsr_rd = 1'b0, rhr_rd = 1'b0;
    logic [7:0] rhr_data, lsr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo_status dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk),
        .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
        .lsr_rd(lsr_rd), .rhr_rd(rhr_rd), .rhr_data(rhr_data), .lsr(lsr)
    );

    typedef struct packed {
        logic       we;
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
        logic       rr;
        logic       lr;
        logic [7:0] exp_lsr;
        logic [7:0] exp_rhr;
    } vec_t;

    // tx_hold_empty=1, tx_shift_empty=0 during the table: bit5 set, bit6 clear
    localparam vec_t VEC [11] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h41, 1'b0, 1'b0, 8'h21, 8'h41}, // R2 clean push
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'h55, 1'b0, 1'b0, 8'hA1, 8'h41}, // R7 tagged behind head
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hA1, 8'h41}, // R5 status read only
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hA5, 8'h55}, // R3 parity head
        '{1'b1, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b1, 1'b0, 8'hB1, 8'h00}, // R4 break + pop
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'h33, 1'b0, 1'b0, 8'hB1, 8'h00}, // R7 framing behind
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hA9, 8'h33}, // R3 framing head
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h20, 8'h00}, // R7 last tag leaves
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h20, 8'h00}, // R6 empty read
        '{1'b1, 1'b0, 1'b0, 1'b0, 8'h12, 1'b1, 1'b0, 8'h21, 8'h12}, // R6 push+read on empty
        '{1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h20, 8'h00}  // R6 pop to empty
    };

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_par = 1'b0; wr_frm = 1'b0; wr_brk = 1'b0;
        wr_data = 8'h00; lsr_rd = 1'b0; rhr_rd = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk8("R1 lsr in reset", lsr, 8'h20);
        rst_n = 1'b1;
        @(negedge clk);
        chk8("R1 lsr after reset", lsr, 8'h20);
        chk8("R1 rhr after reset", rhr_data, 8'h00);

        foreach (VEC[i]) begin
            wr_en = VEC[i].we; wr_brk = VEC[i].brk; wr_frm = VEC[i].frm;
            wr_par = VEC[i].par; wr_data = VEC[i].data;
            rhr_rd = VEC[i].rr; lsr_rd = VEC[i].lr;
            step();
            chk8($sformatf("R2-table lsr vec %0d", i), lsr, VEC[i].exp_lsr);
            chk8($sformatf("R3-table rhr vec %0d", i), rhr_data, VEC[i].exp_rhr);
        end

        // R9 transmitter bits
        tx_hold_empty = 1'b0; tx_shift_empty = 1'b0; #1;
        chk8("R9 both busy", lsr & 8'h60, 8'h00);
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b1; #1;
        chk8("R9 both empty", lsr & 8'h60, 8'h60);
        tx_hold_empty = 1'b0; tx_shift_empty = 1'b1; #1;
        chk8("R9 shift only", lsr & 8'h60, 8'h00);
        tx_hold_empty = 1'b1; tx_shift_empty = 1'b0; #1;

        // R10 fill to capacity, one parity-tagged entry at index 10
        for (int i = 0; i < 64; i++) begin
            wr_en = 1'b1; wr_data = 8'(i + 1); wr_par = (i == 10);
            step();
        end
        chk8("R10 full, no overrun", lsr & 8'h83, 8'h81);
        wr_en = 1'b1; wr_data = 8'hEE;
        step();
        chk8("R8 overrun set", lsr & 8'h02, 8'h02);
        step();
        chk8("R8 overrun held", lsr & 8'h02, 8'h02);
        lsr_rd = 1'b1; #1;
        chk8("R8 flag visible during read", lsr & 8'h02, 8'h02);
        step();
        chk8("R8 cleared after status read", lsr & 8'h02, 8'h00);
        chk8("R5 head kept after status read", rhr_data, 8'h01);

        // R8 read and drop in same cycle keeps flag
        wr_en = 1'b1; wr_data = 8'hDD;
        step();
        lsr_rd = 1'b1; wr_en = 1'b1; wr_data = 8'hDE;
        step();
        chk8("R8 simultaneous drop keeps flag", lsr & 8'h02, 8'h02);
        lsr_rd = 1'b1;
        step();

        // R10 drain in order; R7 flag drops after tagged entry leaves
        for (int i = 0; i < 64; i++) begin
            chk8($sformatf("R10 order entry %0d", i), rhr_data, 8'(i + 1));
            if (i == 10) chk8("R3 tagged head parity", lsr & 8'h1C, 8'h04);
            rhr_rd = 1'b1;
            step();
            if (i == 9)  chk8("R7 flag before tagged pop", lsr & 8'h80, 8'h80);
            if (i == 10) chk8("R7 flag after tagged pop", lsr & 8'h80, 8'h00);
        end
        chk8("R10 dropped bytes absent", lsr, 8'h20);
        chk8("R6 rhr empty after drain", rhr_data, 8'h00);

        // R7 simultaneous push tagged and pop tagged keeps count
        wr_en = 1'b1; wr_frm = 1'b1; wr_data = 8'h61;
        step();
        wr_en = 1'b1; wr_par = 1'b1; wr_data = 8'h62; rhr_rd = 1'b1;
        step();
        chk8("R7 swap tagged entries", lsr, 8'hA5);
        rhr_rd = 1'b1;
        step();
        chk8("R7 cleared after last", lsr, 8'h20);

        done = 1'b1;
        finish_run();
    end
endmodule